// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Atomic Hold

This block shares one memory bus among a set of requesting processors. It grants the bus one cycle at a time. When no atomic operation is in progress, ownership can move on every cycle, and contending requesters are served in round-robin order. Each processor has a request line and an active-low lock line. A processor that is performing an indivisible read-modify-write keeps its lock line low for the whole operation. While the processor that currently owns the bus holds its lock line low, the arbiter keeps the grant on that processor. No other processor can then slip an access between the read and the write.

The grant is registered. Requests and lock levels sampled at a rising clock edge decide the grant that is visible during the following cycle. The current owner is also presented as a binary index with a valid flag.

Top module: `bus_rr_lock_arbiter`

## Requirements
- R1: During and directly after reset, no grant is asserted, owner_valid is low, and the round-robin search starts at requester 0.
- R2: At most one bit of gnt is high in any cycle. When owner_valid is high, the gnt bit at position owner_idx is the one that is set, and owner_idx equals that bit position.
- R3: The grant is registered. Requests sampled at a rising edge produce their grant in the next cycle. If no request is present and no lock is held at an edge, no grant is asserted in the next cycle. If any request is present at an edge, some grant is asserted in the next cycle.
- R4: When no lock is held, the next grant goes to the first requester found by searching upward from the position just after the most recently granted requester, wrapping from NUM_REQ-1 to 0.
- R5: If the current owner's lock_n bit is low (0 = locked) at an edge, that owner keeps the grant for the next cycle. This holds whether or not its req bit is set and whatever other requesters do.
- R6: A low lock_n bit from a requester that does not hold the grant has no effect. Such a requester is arbitrated like any other, using its req bit only.
- R7: When a locked owner releases its lock (lock_n back to 1), the search for the next owner begins at the position after that owner. A requester that was blocked by the lock is therefore served ahead of the releasing owner.
- R8: With every requester asserting req and no lock held, grants visit requesters 0,1,...,NUM_REQ-1 in order, one per cycle, and then wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_REQ | Bus request, one bit per requester |
| lock_n | input | NUM_REQ | Atomic hold, active low, one bit per requester |
| gnt | output | NUM_REQ | One-hot bus grant |
| owner_idx | output | $clog2(NUM_REQ) | Index of the requester granted this cycle |
| owner_valid | output | 1 | High when some requester holds the grant |

## Verification
The bench builds the arbiter with the default NUM_REQ of 4. With four requesters, every wrap of the round-robin pointer is reachable within a few cycles. So is every case where a lock is held while three other requesters contend. A bench-side model of the owner and the search start predicts each cycle's grant. Directed scenarios cover lock entry, a lock held while the owner's own request drops, foreign lock assertions, and release ordering.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // Position following idx in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Position offset steps after base in a ring of n entries.
  function automatic int unsigned ring_add(input int unsigned base, input int unsigned offset,
                                           input int unsigned n);
    return (base + offset) % n;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_REQ = 4,
  localparam int IDXW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic [IDXW-1:0]    start_idx,
  output logic               pick_valid,
  output logic [IDXW-1:0]    pick_idx
);
  import rr_arb_pkg::*;

  // The loop walks from the farthest offset down to offset 0, so the requester
  // closest to start_idx is the last one written and wins.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      int unsigned cand;
      cand = ring_add(int'(start_idx), k, NUM_REQ);
      if (req[cand]) begin
        pick_valid = 1'b1;
        pick_idx   = IDXW'(cand);
      end
    end
  end

endmodule

// File: rtl/lock_hold.sv
module lock_hold #(
  parameter int NUM_REQ = 4,
  localparam int IDXW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               owner_valid_q,
  input  logic [IDXW-1:0]    owner_q,
  input  logic [NUM_REQ-1:0] lock_n,
  output logic               hold
);
  // Only the lock line of the current owner is looked at.
  // The lock lines of all other requesters are ignored.
  assign hold = owner_valid_q && !lock_n[owner_q];

endmodule

// File: rtl/grant_decode.sv
module grant_decode #(
  parameter int NUM_REQ = 4,
  localparam int IDXW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               valid,
  input  logic [IDXW-1:0]    idx,
  output logic [NUM_REQ-1:0] onehot
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    assign onehot[g] = valid && (idx == IDXW'(g));
  end

endmodule

// File: rtl/bus_rr_lock_arbiter.sv
module bus_rr_lock_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDXW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] lock_n,
  output logic [NUM_REQ-1:0] gnt,
  output logic [IDXW-1:0]    owner_idx,
  output logic               owner_valid
);
  import rr_arb_pkg::*;

  // Registered state: current owner, and where the next search begins.
  logic [IDXW-1:0] owner_q;
  logic            owner_valid_q;
  logic [IDXW-1:0] search_q;

  // Named internal events, used by the checker.
  logic            lock_active;
  logic            pick_valid;
  logic [IDXW-1:0] pick_idx;
  logic            new_grant;
  logic [IDXW-1:0] owner_d;
  logic            owner_valid_d;
  logic [IDXW-1:0] search_d;

  lock_hold #(.NUM_REQ(NUM_REQ)) u_hold (
    .owner_valid_q (owner_valid_q),
    .owner_q       (owner_q),
    .lock_n        (lock_n),
    .hold          (lock_active)
  );

  rr_pick #(.NUM_REQ(NUM_REQ)) u_pick (
    .req        (req),
    .start_idx  (search_q),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign new_grant = !lock_active && pick_valid;

  always_comb begin
    owner_d       = owner_q;
    owner_valid_d = owner_valid_q;
    search_d      = search_q;
    if (lock_active) begin
      owner_d       = owner_q;
      owner_valid_d = 1'b1;
    end else if (pick_valid) begin
      owner_d       = pick_idx;
      owner_valid_d = 1'b1;
      search_d      = IDXW'(ring_next(int'(pick_idx), NUM_REQ));
    end else begin
      owner_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q       <= '0;
      owner_valid_q <= 1'b0;
      search_q      <= '0;
    end else begin
      owner_q       <= owner_d;
      owner_valid_q <= owner_valid_d;
      search_q      <= search_d;
    end
  end

  grant_decode #(.NUM_REQ(NUM_REQ)) u_dec (
    .valid  (owner_valid_q),
    .idx    (owner_q),
    .onehot (gnt)
  );

  assign owner_idx   = owner_q;
  assign owner_valid = owner_valid_q;

endmodule

// File: rtl/rr_lock_checker.sv
module rr_lock_checker #(
  parameter int NUM_REQ = 4,
  localparam int IDXW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req,
  input logic [NUM_REQ-1:0] lock_n,
  input logic [NUM_REQ-1:0] gnt,
  input logic [IDXW-1:0]    owner_idx,
  input logic               owner_valid,
  input logic               lock_active
);
  logic [NUM_REQ-1:0] req_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_seen <= '0;
    else        req_seen <= req;
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_idx_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid |-> (gnt[owner_idx] && $countones(gnt) == 1));

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && !lock_active) |=> !owner_valid);

  assert_serve_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> owner_valid);

  assert_lock_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && !lock_n[owner_idx]) |=> (owner_valid && owner_idx == $past(owner_idx)));

  assert_foreign_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |=> (!owner_valid || req_seen[owner_idx]));

endmodule

bind bus_rr_lock_arbiter rr_lock_checker #(.NUM_REQ(NUM_REQ)) u_rr_lock_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .lock_n      (lock_n),
  .gnt         (gnt),
  .owner_idx   (owner_idx),
  .owner_valid (owner_valid),
  .lock_active (lock_active)
);

// File: tb/bus_rr_lock_arbiter_bench.sv
module bus_rr_lock_arbiter_bench;
  localparam int N = 4;
  localparam int W = 2;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] lock_n = '1;
  logic [N-1:0] gnt;
  logic [W-1:0] owner_idx;
  logic         owner_valid;

  int tests = 0;
  int fails = 0;

  // Bench-side expectation state.
  int exp_owner = 0;
  bit exp_valid = 0;
  int exp_start = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_rr_lock_arbiter #(.NUM_REQ(N)) u_bus_rr_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .lock_n(lock_n),
    .gnt(gnt), .owner_idx(owner_idx), .owner_valid(owner_valid)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  // Advance the expectation by one edge, following R4/R5/R6/R7.
  task automatic model_step(input logic [N-1:0] r, input logic [N-1:0] ln);
    if (exp_valid && ln[exp_owner] == 1'b0) begin
      exp_valid = 1;
    end else begin
      bit found = 0;
      for (int k = 0; k < N && !found; k++) begin
        int c = (exp_start + k) % N;
        if (r[c]) begin
          found = 1; exp_owner = c; exp_start = (c + 1) % N;
        end
      end
      exp_valid = found;
    end
  endtask

  function automatic logic [N-1:0] exp_gnt();
    return exp_valid ? (N'(1) << exp_owner) : '0;
  endfunction

  // One cycle: drive after the falling edge, sample just after the rising edge.
  task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] ln, input string tag);
    @(negedge clk);
    req = r; lock_n = ln;
    @(posedge clk);
    model_step(r, ln);
    #1;
    check(tag, gnt, exp_gnt());
    tests++;
    if (exp_valid && (owner_valid !== 1'b1 || int'(owner_idx) != exp_owner)) begin
      fails++;
      $display("FAIL R2 owner: valid=%b idx=%0d expected idx=%0d", owner_valid, owner_idx, exp_owner);
    end else if (!exp_valid && owner_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 owner_valid: %b expected 0", owner_valid);
    end
  endtask

  task automatic t_reset_R1;
    rst_n = 0; req = '1; lock_n = '0;
    exp_valid = 0; exp_owner = 0; exp_start = 0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 during reset", gnt, '0);
    @(negedge clk); req = '0; lock_n = '1; rst_n = 1;
    #1;
    check("R1 after reset", gnt, '0);
  endtask

  task automatic t_register_R3;
    cyc(4'b0000, 4'b1111, "R3 idle");
    cyc(4'b0100, 4'b1111, "R3 single request");
    cyc(4'b0000, 4'b1111, "R3 release to idle");
    cyc(4'b0001, 4'b1111, "R3 req0");
  endtask

  task automatic t_rotate_R8;
    t_reset_R1();
    for (int i = 0; i < 2 * N; i++) cyc(4'b1111, 4'b1111, "R8 full rotation");
    check("R8 wrap end on 3", gnt, 4'b1000);
  endtask

  task automatic t_search_R4;
    cyc(4'b1010, 4'b1111, "R4 from 0 picks 1");
    cyc(4'b1010, 4'b1111, "R4 next picks 3");
    cyc(4'b1010, 4'b1111, "R4 wrap picks 1");
    cyc(4'b0101, 4'b1111, "R4 picks 2");
    cyc(4'b0101, 4'b1111, "R4 wrap picks 0");
  endtask

  task automatic t_lock_R5;
    cyc(4'b0010, 4'b1111, "R5 grant 1");
    check("R5 owner is 1", gnt, 4'b0010);
    cyc(4'b1111, 4'b1101, "R5 lock held read");
    cyc(4'b1111, 4'b1101, "R5 lock held write");
    check("R5 stays on 1", gnt, 4'b0010);
    cyc(4'b1101, 4'b1101, "R5 held without own req");
    check("R5 still 1", gnt, 4'b0010);
  endtask

  task automatic t_release_R7;
    cyc(4'b1111, 4'b1111, "R7 release picks 2");
    check("R7 next after locked owner", gnt, 4'b0100);
  endtask

  task automatic t_foreign_R6;
    cyc(4'b0001, 4'b1111, "R6 grant 0");
    cyc(4'b0001, 4'b0111, "R6 foreign lock no req");
    check("R6 requester 3 not granted", gnt, 4'b0001);
    cyc(4'b1001, 4'b0111, "R6 foreign lock with req");
    check("R6 3 granted by req", gnt, 4'b1000);
    cyc(4'b0001, 4'b1111, "R6 3 not held after release");
    check("R6 moves to 0", gnt, 4'b0001);
  endtask

  initial begin
    t_reset_R1();
    t_register_R3();
    t_search_R4();
    t_lock_R5();
    t_release_R7();
    t_foreign_R6();
    t_rotate_R8();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule